// File: doc/BRIEF.md
# CAN Controller Sleep and Wake Sequencer

This block controls the low-power sequence of a CAN controller. Software writes a small control register to request a halt (controller taken off the bus), to request sleep, and to choose whether bus activity may end sleep on its own. The sequencer holds a sleep request until the protocol engine reports an idle bus. A request made while halted is honoured at once, because the controller is already off the bus.

Sleep ends in one of two ways. Software can clear the sleep bit, or, if wake-on-bus is selected, a recessive-to-dominant edge on the synchronized RX line ends it. A wake from the bus tells the receive path to drop the frame in flight. Any edge seen during sleep sets an interrupt flag, and that flag is gated by a mask bit. After any wake, and after reset, communication stays disabled until eleven consecutive recessive bit samples have been taken.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status level. The protocol engine supplies `bit_strobe_i`, `bus_idle_i` and `frame_done_i` as single-cycle or level handshakes. It never stalls the block, and the block never stalls it.

Top module: `can_sleep_seq`

## Requirements
- R1: With the sleep bit (control bit 1) set and the controller running, `sleep_o` rises on the clock edge after the first cycle in which `bus_idle_i` is high. It stays low for as long as `bus_idle_i` is low.
- R2: With the halt bit (control bit 0) set and the controller running, `halted_o` rises on the edge after a cycle with `bus_idle_i` high. It stays high until the halt bit is cleared.
- R3: A single control write that clears the halt bit and sets the sleep bit moves the block from halted directly into sleep, without regard to `bus_idle_i`.
- R4: Writing 0 to the sleep bit during sleep returns the block to running on the following edge.
- R5: During sleep, a 1-to-0 transition of `rx_i` ends sleep and clears the sleep bit only when the wake-on-bus bit (control bit 2) is 1. When that bit is 0 the block stays asleep.
- R6: A 1-to-0 transition of `rx_i` during sleep sets `irq_flag_o`. A write to the interrupt register (`reg_sel_i`=1) with bit 0 set clears the flag, but a new edge in the same cycle wins over the clear. Bit 1 of that register is the mask, and `irq_o` equals flag AND mask.
- R7: A wake from bus activity raises `drop_frame_o` on the same edge that ends sleep. It holds until a `frame_done_i` pulse, and later frames are not flagged.
- R8: `comm_en_o` is high only while running and after at least 11 consecutive `bit_strobe_i` samples with `rx_i`=1. A strobe that samples `rx_i`=0 restarts the count. The count holds at 11, and halt or sleep clears it.
- R9: After reset the block is running and not halted, with sleep and halt bits 0, flag and mask 0, and `comm_en_o`, `drop_frame_o` and `irq_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: control register, 1: interrupt register |
| reg_wdata_i | input | 3 | Write data (control: bit0 halt, bit1 sleep, bit2 wake-on-bus; interrupt: bit0 clear flag, bit1 mask) |
| rx_i | input | 1 | Synchronized RX line, 1 = recessive |
| bit_strobe_i | input | 1 | One-cycle pulse at each bit sample point |
| bus_idle_i | input | 1 | Protocol engine reports an idle bus |
| frame_done_i | input | 1 | Pulse at the end of a received frame |
| sleep_o | output | 1 | Block is in sleep |
| halted_o | output | 1 | Disconnection from the bus is confirmed |
| comm_en_o | output | 1 | Protocol engine may communicate |
| drop_frame_o | output | 1 | Receive path must discard the current frame |
| irq_flag_o | output | 1 | Bus-activity interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can meet in one cycle: a bus edge that sets the interrupt flag, and a software write that clears it. The bench issues the clear write in the same cycle as the RX fall that also wakes the block from sleep. It then expects the flag to stay set, the sleep bit to drop, and `drop_frame_o` to rise together. A behavioural model in the bench predicts every output on every clock, so a wrong priority between these events shows up at once.

// File: rtl/can_slp_pkg.sv
package can_slp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_SLEEP = 2'd2
  } slp_state_e;

  localparam int unsigned WDATA_W     = 3;
  localparam int unsigned CTL_HALT    = 0;
  localparam int unsigned CTL_SLEEP   = 1;
  localparam int unsigned CTL_WAKESEL = 2;
  localparam int unsigned INT_CLR     = 0;
  localparam int unsigned INT_MASK    = 1;
endpackage

// File: rtl/can_slp_regs.sv
module can_slp_regs
  import can_slp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [WDATA_W-1:0] reg_wdata_i,
  input  logic               bus_wake_i,
  input  logic               edge_in_sleep_i,
  output logic               halt_q_o,
  output logic               sleep_q_o,
  output logic               wsel_q_o,
  output logic               mask_q_o,
  output logic               flag_q_o
);
  logic ctl_wr, int_wr;
  assign ctl_wr = reg_wr_i && !reg_sel_i;
  assign int_wr = reg_wr_i &&  reg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q_o  <= 1'b0;
      sleep_q_o <= 1'b0;
      wsel_q_o  <= 1'b0;
    end else if (ctl_wr) begin
      halt_q_o  <= reg_wdata_i[CTL_HALT];
      sleep_q_o <= reg_wdata_i[CTL_SLEEP];
      wsel_q_o  <= reg_wdata_i[CTL_WAKESEL];
    end else if (bus_wake_i) begin
      sleep_q_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q_o <= 1'b0;
      flag_q_o <= 1'b0;
    end else begin
      if (int_wr) mask_q_o <= reg_wdata_i[INT_MASK];
      if (edge_in_sleep_i)
        flag_q_o <= 1'b1;
      else if (int_wr && reg_wdata_i[INT_CLR])
        flag_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_slp_quiet.sv
module can_slp_quiet #(
  parameter int unsigned QUIET_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic bit_strobe_i,
  input  logic count_en_i,
  output logic rx_fall_o,
  output logic quiet_o
);
  localparam int unsigned CW = $clog2(QUIET_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUIET_BITS);

  logic          rx_prev;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_prev <= 1'b1;
    else         rx_prev <= rx_i;
  end
  assign rx_fall_o = rx_prev && !rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt <= '0;
    else if (!count_en_i)    cnt <= '0;
    else if (bit_strobe_i) begin
      if (!rx_i)             cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end
  assign quiet_o = (cnt == LIMIT);
endmodule

// File: rtl/can_slp_fsm.sv
module can_slp_fsm
  import can_slp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_q_i,
  input  logic       sleep_q_i,
  input  logic       wsel_q_i,
  input  logic       rx_fall_i,
  input  logic       bus_idle_i,
  input  logic       frame_done_i,
  output slp_state_e state_o,
  output logic       bus_wake_o,
  output logic       drop_o
);
  slp_state_e nxt;

  assign bus_wake_o = (state_o == ST_SLEEP) && wsel_q_i && rx_fall_i;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      ST_RUN: begin
        if (sleep_q_i && bus_idle_i)     nxt = ST_SLEEP;
        else if (halt_q_i && bus_idle_i) nxt = ST_HALT;
      end
      ST_HALT: begin
        if (!halt_q_i) nxt = sleep_q_i ? ST_SLEEP : ST_RUN;
      end
      ST_SLEEP: begin
        if (bus_wake_o || !sleep_q_i) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_RUN;
      drop_o  <= 1'b0;
    end else begin
      state_o <= nxt;
      if (bus_wake_o)        drop_o <= 1'b1;
      else if (frame_done_i) drop_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_sleep_seq.sv
module can_sleep_seq
  import can_slp_pkg::*;
#(
  parameter int unsigned QUIET_BITS = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [WDATA_W-1:0] reg_wdata_i,
  input  logic               rx_i,
  input  logic               bit_strobe_i,
  input  logic               bus_idle_i,
  input  logic               frame_done_i,
  output logic               sleep_o,
  output logic               halted_o,
  output logic               comm_en_o,
  output logic               drop_frame_o,
  output logic               irq_flag_o,
  output logic               irq_o
);
  logic       halt_q, sleep_q, wsel_q, mask_q;
  logic       rx_fall, quiet, bus_wake;
  slp_state_e state;

  can_slp_regs u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_wr_i        (reg_wr_i),
    .reg_sel_i       (reg_sel_i),
    .reg_wdata_i     (reg_wdata_i),
    .bus_wake_i      (bus_wake),
    .edge_in_sleep_i (rx_fall && (state == ST_SLEEP)),
    .halt_q_o        (halt_q),
    .sleep_q_o       (sleep_q),
    .wsel_q_o        (wsel_q),
    .mask_q_o        (mask_q),
    .flag_q_o        (irq_flag_o)
  );

  can_slp_quiet #(.QUIET_BITS(QUIET_BITS)) u_quiet (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_i         (rx_i),
    .bit_strobe_i (bit_strobe_i),
    .count_en_i   (state == ST_RUN),
    .rx_fall_o    (rx_fall),
    .quiet_o      (quiet)
  );

  can_slp_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_q_i     (halt_q),
    .sleep_q_i    (sleep_q),
    .wsel_q_i     (wsel_q),
    .rx_fall_i    (rx_fall),
    .bus_idle_i   (bus_idle_i),
    .frame_done_i (frame_done_i),
    .state_o      (state),
    .bus_wake_o   (bus_wake),
    .drop_o       (drop_frame_o)
  );

  assign sleep_o   = (state == ST_SLEEP);
  assign halted_o  = (state == ST_HALT);
  assign comm_en_o = (state == ST_RUN) && quiet;
  assign irq_o     = irq_flag_o && mask_q;
endmodule

// File: rtl/can_sleep_seq_chk.sv
module can_sleep_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic bus_idle_i,
  input logic sleep_o,
  input logic halted_o,
  input logic comm_en_o,
  input logic drop_frame_o,
  input logic irq_flag_o,
  input logic irq_o
);
  p_sleep_needs_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !$past(sleep_o) && !$past(halted_o)) |-> $past(bus_idle_i));

  p_halt_needs_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(bus_idle_i));

  p_irq_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_flag_o);

  p_drop_on_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drop_frame_o) |-> ($past(sleep_o) && !sleep_o));

  p_comm_after_recessive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(comm_en_o) |-> $past(rx_i));

  p_comm_off_low_power_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o || halted_o) |-> !comm_en_o);

  p_single_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sleep_o && halted_o));
endmodule

bind can_sleep_seq can_sleep_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_i         (rx_i),
  .bus_idle_i   (bus_idle_i),
  .sleep_o      (sleep_o),
  .halted_o     (halted_o),
  .comm_en_o    (comm_en_o),
  .drop_frame_o (drop_frame_o),
  .irq_flag_o   (irq_flag_o),
  .irq_o        (irq_o)
);

// File: tb/can_sleep_seq_tb.sv
`timescale 1ns/1ps
module can_sleep_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic       rx = 1'b1, strobe = 1'b0, idle = 1'b1, fdone = 1'b0;
  logic       sleep_o, halted_o, comm_en_o, drop_o, flag_o, irq_o;

  int errors = 0;
  int checks = 0;
  int tick = 0;

  always #5 clk = ~clk;

  can_sleep_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .rx_i(rx), .bit_strobe_i(strobe),
    .bus_idle_i(idle), .frame_done_i(fdone), .sleep_o(sleep_o),
    .halted_o(halted_o), .comm_en_o(comm_en_o), .drop_frame_o(drop_o),
    .irq_flag_o(flag_o), .irq_o(irq_o)
  );

  // behavioural reference model: mode 0 run, 1 halted, 2 asleep
  int m_mode = 0, m_quiet = 0;
  bit m_halt, m_sleep, m_wsel, m_mask, m_flag, m_drop, m_rxp = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_quiet = 0; m_halt = 0; m_sleep = 0; m_wsel = 0;
      m_mask = 0; m_flag = 0; m_drop = 0; m_rxp = 1;
    end else begin
      bit edge_seen, wake_bus;
      int nmode;
      edge_seen = m_rxp && !rx;
      wake_bus  = (m_mode == 2) && m_wsel && edge_seen;
      nmode = m_mode;
      if (m_mode == 0) begin
        if (m_sleep && idle) nmode = 2;
        else if (m_halt && idle) nmode = 1;
      end else if (m_mode == 1) begin
        if (!m_halt) nmode = m_sleep ? 2 : 0;
      end else if (wake_bus || !m_sleep) nmode = 0;
      if (m_mode != 0) m_quiet = 0;
      else if (strobe) m_quiet = rx ? ((m_quiet < 11) ? m_quiet + 1 : 11) : 0;
      if (m_mode == 2 && edge_seen) m_flag = 1;
      else if (reg_wr && reg_sel && reg_wdata[0]) m_flag = 0;
      if (reg_wr && reg_sel) m_mask = reg_wdata[1];
      if (reg_wr && !reg_sel) begin
        m_halt = reg_wdata[0]; m_sleep = reg_wdata[1]; m_wsel = reg_wdata[2];
      end else if (wake_bus) m_sleep = 0;
      if (wake_bus) m_drop = 1;
      else if (fdone) m_drop = 0;
      m_rxp = rx;
      m_mode = nmode;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: sample away from the edge, compare to model, advance strobe
  task automatic step();
    @(negedge clk);
    chk(sleep_o,   m_mode == 2, "R1 sleep_o");
    chk(halted_o,  m_mode == 1, "R2 halted_o");
    chk(comm_en_o, (m_mode == 0) && (m_quiet == 11), "R8 comm_en_o");
    chk(drop_o,    m_drop, "R7 drop_frame_o");
    chk(flag_o,    m_flag, "R6 irq_flag_o");
    chk(irq_o,     m_flag && m_mask, "R6 irq_o");
    tick++;
    strobe = (tick % 4 == 0);
    reg_wr = 1'b0;
    fdone  = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(sleep_o, 0, "R9 sleep"); chk(halted_o, 0, "R9 halted");
    chk(comm_en_o, 0, "R9 comm"); chk(drop_o, 0, "R9 drop"); chk(irq_o, 0, "R9 irq");
    rst_n = 1'b1;
    run(60);
    chk(comm_en_o, 1, "R8 quiet reached");
    rx = 1'b0; run(5); rx = 1'b1;   // dominant sample restarts the count
    chk(comm_en_o, 0, "R8 dominant restarts");
    run(60);
    // R1: sleep waits for idle
    idle = 1'b0;
    wr(0, 3'b010); run(10);
    chk(sleep_o, 0, "R1 held while busy");
    idle = 1'b1; run(2);
    chk(sleep_o, 1, "R1 entered on idle");
    // R4: software wake
    wr(0, 3'b000); run(1);
    chk(sleep_o, 0, "R4 software wake");
    run(10);
    // R5/R6: sleep without wake-on-bus, edge sets flag only
    wr(0, 3'b010); run(3);
    rx = 1'b0; run(2); rx = 1'b1; run(2);
    chk(sleep_o, 1, "R5 no bus wake");
    chk(irq_o, 0, "R6 masked");
    wr(1, 3'b010); run(1);
    chk(irq_o, 1, "R6 unmasked");
    wr(1, 3'b011); run(1);
    chk(flag_o, 0, "R6 cleared");
    wr(0, 3'b000); run(60);
    // R2/R3: halt, then straight to sleep with the bus busy
    wr(0, 3'b001); run(3);
    chk(halted_o, 1, "R2 halted");
    idle = 1'b0;
    wr(0, 3'b110); run(2);
    chk(sleep_o, 1, "R3 halt to sleep");
    // R6/R7: bus wake with a flag clear in the same cycle
    rx = 1'b0; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 3'b011;
    step(); rx = 1'b1;
    chk(flag_o, 1, "R6 set beats clear");
    chk(sleep_o, 0, "R5 bus wake");
    chk(drop_o, 1, "R7 drop raised");
    run(8);
    fdone = 1'b1; step(); run(2);
    chk(drop_o, 0, "R7 drop released");
    rx = 1'b0; step(); rx = 1'b1; run(3);
    chk(drop_o, 0, "R7 later frame kept");
    idle = 1'b1; run(60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule